// File: doc/BRIEF.md
# Parallel LCD Sync Timing Generator

This block produces the line and frame timing for a 320x240 TFT panel fed over an 8-bit parallel bus, where each pixel takes several bus clocks (two for 16-bit colour, three for 24-bit colour). A line counter runs in bus clocks and a frame counter runs in lines. From these two counters the block drives active-low horizontal and vertical sync. It also drives a line-active strobe and the pixel column, pixel row and colour byte lane that an upstream pixel source uses to put the right byte on the bus.

Every horizontal figure is a pixel count scaled by `CLK_PER_PIX`. The first visible clock of a line is shifted later by a fixed pipeline delay that depends on the colour mode. The vertical pulse begins `VS_LEAD` clocks before the horizontal pulse that opens the frame. The timing has no back-pressure. While `line_active` is high, the pixel source must supply the byte for the reported column, row and lane in that same clock, and it has no way to stall the generator. `en` low parks the generator at the start of a frame with both syncs and the strobe inactive. When `en` rises, the frame starts from line 0, clock 0.

Top module: `lcd_sync_gen`

## Requirements
- R1: A line lasts H_TOTAL_PIX*CLK_PER_PIX bus clocks and a frame lasts V_ACT+V_BLANK lines. The line counter wraps to clock 0 and, at the end of the last line, the frame wraps to line 0.
- R2: `hs_n` is low during clocks 0 .. H_SYNC_PIX*CLK_PER_PIX-1 of every line and high otherwise.
- R3: `vs_n` is low for V_SYNC_PIX*CLK_PER_PIX clocks. The low period starts VS_LEAD clocks before clock 0 of line 0, in the last clocks of the previous frame's last line. In the first frame after enable, only the part from line 0, clock 0 onward appears.
- R4: Within a line, `line_active` is high for H_ACT_PIX*CLK_PER_PIX clocks starting at clock H_START_PIX*CLK_PER_PIX+D. The delay D is 3 when CLK_PER_PIX is 2 and 5 otherwise.
- R5: `line_active` is high only on lines V_BLANK/2 .. V_BLANK/2+V_ACT-1, so half of the blanking lines come before the first visible line.
- R6: While `line_active` is high, `pix_lane` counts 0 .. CLK_PER_PIX-1 within each pixel and `pix_x` is the pixel column counted from 0. `pix_y` is the line number minus V_BLANK/2. All three are 0 while `line_active` is low.
- R7: While `en` is low, `hs_n` and `vs_n` are high and `line_active` is low. The counters return to zero, so the first enabled clock is line 0, clock 0.
- R8: The synchronous reset `rst` overrides `en`. It gives the same quiet outputs and zeroed counters as R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the timing at frame start |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| line_active | output | 1 | High while the bus carries visible pixel bytes |
| pix_x | output | XW | Pixel column within the visible line |
| pix_y | output | YW | Visible line number |
| pix_lane | output | LW | Colour byte lane within the current pixel |

## Verification
The assertions assume that `rst` is high from time zero until the first clock edges have cleared the counters. They also assume that the parameters give a visible window ending inside the line and a vertical pulse head no longer than one line. The bench holds `rst` from the start. It runs two small configurations, one per colour mode, whose windows satisfy those limits, and it changes `en` and `rst` only between clock edges. Because each enable rise restarts the frame, the restart lines up with the bench's own position count.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  // Extra bus clocks before the first visible byte, per colour mode
  function automatic int pipe_delay(input int cpp);
    return (cpp == 2) ? 3 : 5;
  endfunction

  // Width of a counter holding 0 .. n-1, never below one bit
  function automatic int cw(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lcd_hcount.sv
module lcd_hcount #(
  parameter int HT      = 1008,
  parameter int H_START = 26,
  parameter int CPP     = 3,
  parameter int HW      = 10,
  parameter int XW      = 9,
  parameter int LW      = 2
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [HW-1:0] h_q,
  output logic          eol,
  output logic [XW-1:0] x_q,
  output logic [LW-1:0] lane_q
);
  localparam logic [HW-1:0] H_LAST   = HW'(HT - 1);
  localparam logic [HW-1:0] PRE_START = HW'(H_START - 1);
  localparam logic [LW-1:0] LANE_LAST = LW'(CPP - 1);

  assign eol = (h_q == H_LAST);

  always_ff @(posedge clk) begin
    if (clr) begin
      h_q    <= '0;
      x_q    <= '0;
      lane_q <= '0;
    end else if (adv) begin
      h_q <= eol ? '0 : h_q + 1'b1;
      if (h_q == PRE_START) begin
        x_q    <= '0;
        lane_q <= '0;
      end else if (lane_q == LANE_LAST) begin
        x_q    <= x_q + 1'b1;
        lane_q <= '0;
      end else begin
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  // R1: position never leaves the line
  p_h_range_r1: assert property (@(posedge clk) disable iff (clr)
    h_q <= H_LAST);

  // R1: last clock of the line is followed by clock 0
  p_h_wrap_r1: assert property (@(posedge clk) disable iff (clr)
    (adv && h_q == H_LAST) |=> (h_q == '0));

  // R6: lane stays inside one pixel
  p_lane_bound_r6: assert property (@(posedge clk) disable iff (clr)
    lane_q <= LANE_LAST);

endmodule

// File: rtl/lcd_vcount.sv
module lcd_vcount #(
  parameter int VT = 244,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [VW-1:0] v_q
);
  localparam logic [VW-1:0] V_LAST = VW'(VT - 1);

  always_ff @(posedge clk) begin
    if (clr)
      v_q <= '0;
    else if (adv)
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
  end

  // R1: frame wraps after the last line
  p_v_wrap_r1: assert property (@(posedge clk) disable iff (clr)
    (adv && v_q == V_LAST) |=> (v_q == '0));

  p_v_range_r1: assert property (@(posedge clk) disable iff (clr)
    v_q <= V_LAST);

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode #(
  parameter int HT      = 1008,
  parameter int VT      = 244,
  parameter int HS_CLKS = 6,
  parameter int VS_CLKS = 6,
  parameter int VS_LEAD = 1,
  parameter int H_START = 26,
  parameter int H_ACT   = 960,
  parameter int V_FIRST = 2,
  parameter int V_ACT   = 240,
  parameter int HW      = 10,
  parameter int VW      = 8,
  parameter int XW      = 9,
  parameter int YW      = 8,
  parameter int LW      = 2
) (
  input  logic          run,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  input  logic [XW-1:0] x,
  input  logic [LW-1:0] lane,
  output logic          hs_n,
  output logic          vs_n,
  output logic          active,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [LW-1:0] pix_lane
);
  localparam logic [HW-1:0] HS_END  = HW'(HS_CLKS);
  localparam logic [HW-1:0] VS_HEAD = HW'(VS_CLKS - VS_LEAD);
  localparam logic [HW-1:0] WIN_LO  = HW'(H_START);
  localparam logic [HW-1:0] WIN_HI  = HW'(H_START + H_ACT);
  localparam logic [VW-1:0] ROW_LO  = VW'(V_FIRST);
  localparam logic [VW-1:0] ROW_HI  = VW'(V_FIRST + V_ACT);
  localparam logic [VW-1:0] V_LAST  = VW'(VT - 1);

  logic vs_tail;
  logic vs_on;
  logic h_win;
  logic v_win;

  generate
    if (VS_LEAD > 0) begin : g_lead
      localparam logic [HW-1:0] TAIL_LO = HW'(HT - VS_LEAD);
      assign vs_tail = (v == V_LAST) && (h >= TAIL_LO);
    end else begin : g_nolead
      assign vs_tail = 1'b0;
    end
  endgenerate

  assign vs_on = ((v == '0) && (h < VS_HEAD)) || vs_tail;
  assign h_win = (h >= WIN_LO) && (h < WIN_HI);
  assign v_win = (v >= ROW_LO) && (v < ROW_HI);

  always_comb begin
    hs_n     = ~(run && (h < HS_END));
    vs_n     = ~(run && vs_on);
    active   = run && h_win && v_win;
    pix_x    = active ? x : '0;
    pix_lane = active ? lane : '0;
    pix_y    = active ? YW'(v - ROW_LO) : '0;
  end

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int CLK_PER_PIX = 3,
  parameter int H_TOTAL_PIX = 336,
  parameter int H_SYNC_PIX  = 2,
  parameter int H_START_PIX = 7,
  parameter int H_ACT_PIX   = 320,
  parameter int V_ACT       = 240,
  parameter int V_BLANK     = 4,
  parameter int V_SYNC_PIX  = 2,
  parameter int VS_LEAD     = 1,
  localparam int XW = cw(H_ACT_PIX),
  localparam int YW = cw(V_ACT),
  localparam int LW = cw(CLK_PER_PIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          hs_n,
  output logic          vs_n,
  output logic          line_active,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic [LW-1:0] pix_lane
);
  localparam int HT      = H_TOTAL_PIX * CLK_PER_PIX;
  localparam int VT      = V_ACT + V_BLANK;
  localparam int H_START = H_START_PIX * CLK_PER_PIX + pipe_delay(CLK_PER_PIX);
  localparam int H_ACT   = H_ACT_PIX * CLK_PER_PIX;
  localparam int HW      = cw(HT);
  localparam int VW      = cw(VT);
  localparam logic [LW-1:0] LANE_LAST = LW'(CLK_PER_PIX - 1);

  logic          run;
  logic          clr;
  logic          eol;
  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic [XW-1:0] x_q;
  logic [LW-1:0] lane_q;

  assign run = en && !rst;
  assign clr = !run;

  lcd_hcount #(
    .HT(HT), .H_START(H_START), .CPP(CLK_PER_PIX),
    .HW(HW), .XW(XW), .LW(LW)
  ) u_h (
    .clk(clk), .clr(clr), .adv(run),
    .h_q(h_q), .eol(eol), .x_q(x_q), .lane_q(lane_q)
  );

  lcd_vcount #(.VT(VT), .VW(VW)) u_v (
    .clk(clk), .clr(clr), .adv(run && eol), .v_q(v_q)
  );

  lcd_sync_decode #(
    .HT(HT), .VT(VT),
    .HS_CLKS(H_SYNC_PIX * CLK_PER_PIX), .VS_CLKS(V_SYNC_PIX * CLK_PER_PIX),
    .VS_LEAD(VS_LEAD), .H_START(H_START), .H_ACT(H_ACT),
    .V_FIRST(V_BLANK / 2), .V_ACT(V_ACT),
    .HW(HW), .VW(VW), .XW(XW), .YW(YW), .LW(LW)
  ) u_dec (
    .run(run), .h(h_q), .v(v_q), .x(x_q), .lane(lane_q),
    .hs_n(hs_n), .vs_n(vs_n), .active(line_active),
    .pix_x(pix_x), .pix_y(pix_y), .pix_lane(pix_lane)
  );

  // R7: disabled generator is quiet
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !en |-> (hs_n && vs_n && !line_active));

  // R8: reset is quiet whatever en does
  p_reset_quiet_r8: assert property (@(posedge clk)
    rst |-> (hs_n && vs_n && !line_active));

  // R6: every visible run starts at column 0, lane 0
  p_run_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(line_active) |-> (pix_x == '0 && pix_lane == '0));

  // R6: lane steps by one inside a pixel
  p_lane_step_r6: assert property (@(posedge clk) disable iff (rst)
    (line_active && $past(line_active) && $past(pix_lane) != LANE_LAST)
      |-> (pix_lane == $past(pix_lane) + 1'b1));

  // R6: column advances when the lane wraps
  p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
    (line_active && $past(line_active) && $past(pix_lane) == LANE_LAST)
      |-> (pix_lane == '0 && pix_x == $past(pix_x) + 1'b1));

endmodule

// File: tb/sim_lcd_sync_gen.sv
module sim_lcd_sync_gen;

  localparam int HTP  = 12;
  localparam int HSP  = 2;
  localparam int HSTP = 2;
  localparam int HAP  = 6;
  localparam int VA   = 4;
  localparam int VBL  = 4;
  localparam int VSP  = 2;
  localparam int LEAD = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;

  always #2 clk = ~clk;

  logic       hs0, vs0, act0;
  logic [2:0] x0;
  logic [1:0] y0;
  logic [1:0] l0;
  logic       hs1, vs1, act1;
  logic [2:0] x1;
  logic [1:0] y1;
  logic [0:0] l1;

  lcd_sync_gen #(
    .CLK_PER_PIX(3), .H_TOTAL_PIX(HTP), .H_SYNC_PIX(HSP), .H_START_PIX(HSTP),
    .H_ACT_PIX(HAP), .V_ACT(VA), .V_BLANK(VBL), .V_SYNC_PIX(VSP), .VS_LEAD(LEAD)
  ) u0 (
    .clk(clk), .rst(rst), .en(en), .hs_n(hs0), .vs_n(vs0),
    .line_active(act0), .pix_x(x0), .pix_y(y0), .pix_lane(l0)
  );

  lcd_sync_gen #(
    .CLK_PER_PIX(2), .H_TOTAL_PIX(HTP), .H_SYNC_PIX(HSP), .H_START_PIX(HSTP),
    .H_ACT_PIX(HAP), .V_ACT(VA), .V_BLANK(VBL), .V_SYNC_PIX(VSP), .VS_LEAD(LEAD)
  ) u1 (
    .clk(clk), .rst(rst), .en(en), .hs_n(hs1), .vs_n(vs1),
    .line_active(act1), .pix_x(x1), .pix_y(y1), .pix_lane(l1)
  );

  int n_chk  = 0;
  int n_fail = 0;
  int t      = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int id, input string what,
                     input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s dut%0d t=%0d %s: actual %0d expected %0d",
               tag, id, t, what, act, exp);
    end
  endtask

  task automatic eval_dut(input int id, input int cpp, input bit r, input bit e,
                          input int a_hs, input int a_vs, input int a_act,
                          input int a_x, input int a_y, input int a_ln);
    int ht, vt, fr, hs0p, h, v, p;
    int e_hs, e_vs, e_act, e_x, e_y, e_ln;
    bit live;
    string qtag;
    ht   = HTP * cpp;
    vt   = VA + VBL;
    fr   = ht * vt;
    hs0p = HSTP * cpp + ((cpp == 2) ? 3 : 5);
    live = e && !r;
    h = t % ht;
    v = (t / ht) % vt;
    p = t % fr;
    if (!live) begin
      qtag = r ? "R8" : "R7";
      e_hs = 1; e_vs = 1; e_act = 0;
    end else begin
      e_hs  = (h < HSP * cpp) ? 0 : 1;
      e_vs  = ((p < VSP * cpp - LEAD) || (p >= fr - LEAD)) ? 0 : 1;
      e_act = (h >= hs0p && h < hs0p + HAP * cpp &&
               v >= VBL / 2 && v < VBL / 2 + VA) ? 1 : 0;
    end
    e_x  = e_act ? (h - hs0p) / cpp : 0;
    e_ln = e_act ? (h - hs0p) % cpp : 0;
    e_y  = e_act ? v - VBL / 2 : 0;
    if (!live) begin
      chk(qtag, id, "hs_n", a_hs, e_hs);
      chk(qtag, id, "vs_n", a_vs, e_vs);
      chk(qtag, id, "line_active", a_act, e_act);
    end else begin
      if (t == 0)      chk("R7", id, "hs_n restart", a_hs, e_hs);
      else if (h == 0) chk("R1", id, "hs_n line start", a_hs, e_hs);
      else             chk("R2", id, "hs_n", a_hs, e_hs);
      chk("R3", id, "vs_n", a_vs, e_vs);
      if (v >= VBL / 2 && v < VBL / 2 + VA) chk("R4", id, "line_active", a_act, e_act);
      else                                  chk("R5", id, "line_active", a_act, e_act);
    end
    chk("R6", id, "pix_x", a_x, e_x);
    chk("R6", id, "pix_y", a_y, e_y);
    chk("R6", id, "pix_lane", a_ln, e_ln);
  endtask

  task automatic cyc(input bit r, input bit e);
    @(negedge clk);
    rst = r;
    en  = e;
    #1;
    eval_dut(0, 3, r, e, int'(hs0), int'(vs0), int'(act0), int'(x0), int'(y0), int'(l0));
    eval_dut(1, 2, r, e, int'(hs1), int'(vs1), int'(act1), int'(x1), int'(y1), int'(l1));
    if (e && !r) t = t + 1;
    else         t = 0;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1);    // R8: reset beats en
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0);    // R7: idle
    for (int i = 0; i < 700; i++) cyc(1'b0, 1'b1);  // R1..R6 over several frames
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0);    // R7: drop en mid-frame
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b1);  // R7: restart at frame start
    for (int i = 0; i < 2; i++) cyc(1'b1, 1'b1);    // R8: reset mid-frame
    for (int i = 0; i < 600; i++) cyc(1'b0, 1'b1);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule